// File: doc/BRIEF.md
# PHY Bring-Up Sequencer

This block takes an Ethernet PHY from power-on to a negotiated link without software help. It talks to the PHY only through a management master port. Each access is a request that carries a register number, a write flag and write data, and it completes when the master returns a done strobe together with any read data. After a start pulse the sequencer resets the PHY and polls until the reset clears. It then loads the interrupt-enable and advertisement registers and polls the status register for completion of autonegotiation. It restarts autonegotiation at a fixed period within the polling loop, and it gives up once a global iteration limit is reached.

Every wait is a count of pulses on a one-millisecond strobe input, so a testbench can shorten the real time by pulsing the strobe more often. When the sequence ends it raises done together with either link_up or fail. These flags hold until the next start.

Top module: `phy_bringup_seq`

## Requirements
- R1: While rst_ni is low, and after it is released, the block is idle: busy_o, done_o, link_up_o, fail_o and mgmt_req_o are all 0.
- R2: A start_i pulse seen while idle launches the sequence. The first access is a write of 0x8000 to register 0. A start_i seen while busy has no effect on the sequence.
- R3: Before every read of register 0 during the reset poll, exactly WAIT_TICKS tick_i pulses occur after the previous access completes. With no tick_i pulses the block issues no further access. A read with bit 15 clear ends the reset poll, and the other bits of that read are ignored.
- R4: When the reset poll read with zero-based index RST_RETRIES+1 still returns bit 15 set, the block finishes with fail. With the default of 3 this is the fifth read, and no later access follows.
- R5: Once the reset has cleared, the block writes 0x3FC0 to register 19 and then, with no wait between them, writes 0x01E1 to register 4. It then waits at least WAIT_TICKS ticks before the next access.
- R6: At every loop iteration n where n mod RESTART_PERIOD is 0, the block writes 0x1200 to register 0 before that iteration's status read. At least WAIT_TICKS ticks pass between that write and the read.
- R7: Each iteration reads register 1. If bit 5 is set the block finishes with link_up. Otherwise it waits at least WAIT_TICKS ticks and starts iteration n+1. Every status read after the first is preceded by at least WAIT_TICKS ticks.
- R8: When the iteration count reaches POLL_LIMIT without success, the block finishes with fail and issues no more accesses. Success on the status read of iteration POLL_LIMIT-1 still gives link_up.
- R9: mgmt_req_o, once high, stays high with mgmt_reg_o, mgmt_we_o and mgmt_wdata_o unchanged until the cycle in which mgmt_done_i is sampled high. mgmt_req_o is only high while busy_o is high.
- R10: done_o, link_up_o and fail_o hold their final values until the next accepted start, which clears them one cycle later. link_up_o and fail_o are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches the bring-up sequence when idle |
| tick_i | input | 1 | One-cycle strobe, one per millisecond |
| mgmt_req_o | output | 1 | Management access request |
| mgmt_we_o | output | 1 | 1 for a write access, 0 for a read |
| mgmt_reg_o | output | 5 | PHY register number |
| mgmt_wdata_o | output | 16 | Write data |
| mgmt_done_i | input | 1 | Access complete strobe from the management master |
| mgmt_rdata_i | input | 16 | Read data, valid with mgmt_done_i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |
| link_up_o | output | 1 | Finished with autonegotiation complete |
| fail_o | output | 1 | Finished because the reset or the negotiation limit ran out |

## Verification
The assertions assume that the management master raises mgmt_done_i only while mgmt_req_o is high, and only for a single cycle per access. They also assume that tick_i is a single-cycle strobe. The bench's PHY model answers only an open request, after a programmable latency of zero to three cycles, and drops done in the following cycle. Ticks come from a divider that can be switched off to hold a wait. Under these rules the holding of the request fields, the exclusive final flags and the absence of requests after the end are checked on every cycle.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RST_WR, S_RST_WAIT, S_RST_RD, S_MSK_WR, S_ADV_WR, S_ADV_WAIT,
    S_LOOP, S_ANEG_WR, S_ANEG_WAIT, S_STAT_RD, S_STAT_WAIT
  } seq_state_e;

  localparam logic [4:0]  REG_CTRL  = 5'd0;
  localparam logic [4:0]  REG_STAT  = 5'd1;
  localparam logic [4:0]  REG_ADV   = 5'd4;
  localparam logic [4:0]  REG_IMASK = 5'd19;

  localparam logic [15:0] VAL_RESET   = 16'h8000;
  localparam logic [15:0] VAL_IMASK   = 16'h3FC0;
  localparam logic [15:0] VAL_ADV     = 16'h01E1;
  localparam logic [15:0] VAL_RESTART = 16'h1200;

  localparam int CTRL_RST_BIT  = 15;
  localparam int STAT_DONE_BIT = 5;
endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int WAIT_TICKS = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int TW = $clog2(WAIT_TICKS + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && tick_i && (cnt_q == TW'(WAIT_TICKS - 1));
endmodule

// File: rtl/phy_seq_count.sv
module phy_seq_count #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
#(
  parameter int RST_RETRIES    = 3,
  parameter int RESTART_PERIOD = 128,
  parameter int POLL_LIMIT     = 1024,
  parameter int KW             = 3,
  parameter int IW             = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mgmt_done_i,
  input  logic [15:0]   mgmt_rdata_i,
  input  logic          wait_exp_i,
  input  logic [KW-1:0] rst_k_i,
  input  logic [IW-1:0] iter_n_i,
  output logic          mgmt_req_o,
  output logic          mgmt_we_o,
  output logic [4:0]    mgmt_reg_o,
  output logic [15:0]   mgmt_wdata_o,
  output logic          wait_run_o,
  output logic          k_clr_o,
  output logic          k_inc_o,
  output logic          n_clr_o,
  output logic          n_inc_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          link_up_o,
  output logic          fail_o
);
  seq_state_e state_q, state_d;
  logic set_fail, set_link, start_go, restart_hit;

  logic unused_rdata;
  assign unused_rdata = ^{mgmt_rdata_i[14:6], mgmt_rdata_i[4:0]};

  generate
    if (RESTART_PERIOD == 1) begin : g_every
      assign restart_hit = 1'b1;
    end else begin : g_mod
      localparam int RW = $clog2(RESTART_PERIOD);
      assign restart_hit = (iter_n_i[RW-1:0] == '0);
    end
  endgenerate

  assign start_go = start_i && (state_q == S_IDLE);

  always_comb begin
    mgmt_req_o = 1'b0; mgmt_we_o = 1'b0; mgmt_reg_o = '0; mgmt_wdata_o = '0;
    unique case (state_q)
      S_RST_WR:  begin mgmt_req_o = 1'b1; mgmt_we_o = 1'b1; mgmt_reg_o = REG_CTRL;  mgmt_wdata_o = VAL_RESET;   end
      S_RST_RD:  begin mgmt_req_o = 1'b1;                   mgmt_reg_o = REG_CTRL;                             end
      S_MSK_WR:  begin mgmt_req_o = 1'b1; mgmt_we_o = 1'b1; mgmt_reg_o = REG_IMASK; mgmt_wdata_o = VAL_IMASK;   end
      S_ADV_WR:  begin mgmt_req_o = 1'b1; mgmt_we_o = 1'b1; mgmt_reg_o = REG_ADV;   mgmt_wdata_o = VAL_ADV;     end
      S_ANEG_WR: begin mgmt_req_o = 1'b1; mgmt_we_o = 1'b1; mgmt_reg_o = REG_CTRL;  mgmt_wdata_o = VAL_RESTART; end
      S_STAT_RD: begin mgmt_req_o = 1'b1;                   mgmt_reg_o = REG_STAT;                             end
      default: ;
    endcase
  end

  assign wait_run_o = (state_q == S_RST_WAIT) || (state_q == S_ADV_WAIT) ||
                      (state_q == S_ANEG_WAIT) || (state_q == S_STAT_WAIT);
  assign busy_o = (state_q != S_IDLE);

  always_comb begin
    state_d = state_q;
    set_fail = 1'b0; set_link = 1'b0;
    k_inc_o = 1'b0; n_inc_o = 1'b0;
    k_clr_o = start_go; n_clr_o = start_go;
    unique case (state_q)
      S_IDLE:     if (start_go) state_d = S_RST_WR;
      S_RST_WR:   if (mgmt_done_i) state_d = S_RST_WAIT;
      S_RST_WAIT: if (wait_exp_i) state_d = S_RST_RD;
      S_RST_RD:
        if (mgmt_done_i) begin
          if (!mgmt_rdata_i[CTRL_RST_BIT]) state_d = S_MSK_WR;
          else if (rst_k_i > KW'(RST_RETRIES)) begin
            state_d = S_IDLE; set_fail = 1'b1;
          end else begin
            k_inc_o = 1'b1; state_d = S_RST_WAIT;
          end
        end
      S_MSK_WR:   if (mgmt_done_i) state_d = S_ADV_WR;
      S_ADV_WR:   if (mgmt_done_i) state_d = S_ADV_WAIT;
      S_ADV_WAIT: if (wait_exp_i) state_d = S_LOOP;
      S_LOOP:
        if (iter_n_i >= IW'(POLL_LIMIT)) begin
          state_d = S_IDLE; set_fail = 1'b1;
        end else if (restart_hit) state_d = S_ANEG_WR;
        else state_d = S_STAT_RD;
      S_ANEG_WR:   if (mgmt_done_i) state_d = S_ANEG_WAIT;
      S_ANEG_WAIT: if (wait_exp_i) state_d = S_STAT_RD;
      S_STAT_RD:
        if (mgmt_done_i) begin
          if (mgmt_rdata_i[STAT_DONE_BIT]) begin
            state_d = S_IDLE; set_link = 1'b1;
          end else state_d = S_STAT_WAIT;
        end
      S_STAT_WAIT:
        if (wait_exp_i) begin
          n_inc_o = 1'b1; state_d = S_LOOP;
        end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      done_o <= 1'b0; link_up_o <= 1'b0; fail_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_go) begin
        done_o <= 1'b0; link_up_o <= 1'b0; fail_o <= 1'b0;
      end else if (set_fail) begin
        done_o <= 1'b1; fail_o <= 1'b1;
      end else if (set_link) begin
        done_o <= 1'b1; link_up_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq #(
  parameter int WAIT_TICKS     = 63,
  parameter int RST_RETRIES    = 3,
  parameter int RESTART_PERIOD = 128,
  parameter int POLL_LIMIT     = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        tick_i,
  output logic        mgmt_req_o,
  output logic        mgmt_we_o,
  output logic [4:0]  mgmt_reg_o,
  output logic [15:0] mgmt_wdata_o,
  input  logic        mgmt_done_i,
  input  logic [15:0] mgmt_rdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        link_up_o,
  output logic        fail_o
);
  localparam int KW = $clog2(RST_RETRIES + 2);
  localparam int IW = $clog2(POLL_LIMIT + 1);

  logic wait_run, wait_exp, k_clr, k_inc, n_clr, n_inc;
  logic [KW-1:0] rst_k;
  logic [IW-1:0] iter_n;

  phy_seq_timer #(.WAIT_TICKS(WAIT_TICKS)) u_timer (
    .clk_i, .rst_ni, .run_i(wait_run), .tick_i, .expire_o(wait_exp)
  );

  phy_seq_count #(.W(KW)) u_rst_cnt (
    .clk_i, .rst_ni, .clr_i(k_clr), .inc_i(k_inc), .cnt_o(rst_k)
  );

  phy_seq_count #(.W(IW)) u_iter_cnt (
    .clk_i, .rst_ni, .clr_i(n_clr), .inc_i(n_inc), .cnt_o(iter_n)
  );

  phy_seq_ctrl #(
    .RST_RETRIES(RST_RETRIES), .RESTART_PERIOD(RESTART_PERIOD),
    .POLL_LIMIT(POLL_LIMIT), .KW(KW), .IW(IW)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .mgmt_done_i, .mgmt_rdata_i,
    .wait_exp_i(wait_exp), .rst_k_i(rst_k), .iter_n_i(iter_n),
    .mgmt_req_o, .mgmt_we_o, .mgmt_reg_o, .mgmt_wdata_o,
    .wait_run_o(wait_run), .k_clr_o(k_clr), .k_inc_o(k_inc),
    .n_clr_o(n_clr), .n_inc_o(n_inc),
    .busy_o, .done_o, .link_up_o, .fail_o
  );
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        mgmt_done_i,
  input logic        mgmt_req_o,
  input logic        mgmt_we_o,
  input logic [4:0]  mgmt_reg_o,
  input logic [15:0] mgmt_wdata_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        link_up_o,
  input logic        fail_o
);
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_req_o && !mgmt_done_i |=> mgmt_req_o && $stable(mgmt_reg_o) &&
                                   $stable(mgmt_we_o) && $stable(mgmt_wdata_o));

  a_r9_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_req_o |-> busy_o);

  a_r2_first_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mgmt_req_o && mgmt_we_o && mgmt_reg_o == 5'd0 &&
                      mgmt_wdata_o == 16'h8000);

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_up_o && fail_o));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(link_up_o) && $stable(fail_o));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !done_o && !link_up_o && !fail_o);

  a_r8_quiet_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mgmt_req_o);
endmodule

bind phy_bringup_seq phy_bringup_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mgmt_done_i(mgmt_done_i),
  .mgmt_req_o(mgmt_req_o), .mgmt_we_o(mgmt_we_o), .mgmt_reg_o(mgmt_reg_o),
  .mgmt_wdata_o(mgmt_wdata_o), .busy_o(busy_o), .done_o(done_o),
  .link_up_o(link_up_o), .fail_o(fail_o)
);

// File: tb/tb_phy_bringup_seq.sv
module tb_phy_bringup_seq;
  localparam int TB_WAIT  = 4;
  localparam int TB_RETRY = 3;
  localparam int TB_RP    = 8;
  localparam int TB_LIMIT = 32;
  localparam int LOGN     = 64;

  typedef struct packed {
    logic [7:0] rbusy;    // reg0 reads that still report reset active
    logic [7:0] aneg_at;  // status read index that reports complete, 255 = never
    logic [7:0] lat;      // response latency in cycles
    logic [7:0] txn;      // expected number of accesses
    logic [7:0] rst_wr;   // expected restart writes
    logic       link;
    logic       fail;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{8'd0, 8'd0,   8'd0, 8'd6,  8'd1, 1'b1, 1'b0},
    '{8'd2, 8'd9,   8'd1, 8'd18, 8'd2, 1'b1, 1'b0},
    '{8'd4, 8'd0,   8'd3, 8'd10, 8'd1, 1'b1, 1'b0},
    '{8'd5, 8'd0,   8'd0, 8'd6,  8'd0, 1'b0, 1'b1},
    '{8'd0, 8'd255, 8'd0, 8'd40, 8'd4, 1'b0, 1'b1},
    '{8'd1, 8'd8,   8'd2, 8'd16, 8'd2, 1'b1, 1'b0},
    '{8'd0, 8'd31,  8'd0, 8'd40, 8'd4, 1'b1, 1'b0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, tick_i = 1'b0;
  logic mgmt_req_o, mgmt_we_o, mgmt_done_i = 1'b0;
  logic [4:0] mgmt_reg_o;
  logic [15:0] mgmt_wdata_o, mgmt_rdata_i = '0;
  logic busy_o, done_o, link_up_o, fail_o;

  always #5 clk_i = ~clk_i;

  phy_bringup_seq #(.WAIT_TICKS(TB_WAIT), .RST_RETRIES(TB_RETRY),
                    .RESTART_PERIOD(TB_RP), .POLL_LIMIT(TB_LIMIT)) dut (
    .clk_i, .rst_ni, .start_i, .tick_i, .mgmt_req_o, .mgmt_we_o, .mgmt_reg_o,
    .mgmt_wdata_o, .mgmt_done_i, .mgmt_rdata_i, .busy_o, .done_o, .link_up_o, .fail_o
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  // PHY model settings
  int m_rbusy = 0, m_aneg = 0, m_lat = 0, m_r0 = 0, m_r1 = 0, m_wait = 0;
  bit tick_en = 1'b1, tick_ph = 1'b0;

  // transaction log
  logic [4:0] lg_reg [LOGN];
  logic lg_we [LOGN];
  logic [15:0] lg_wd [LOGN];
  int lg_gap [LOGN];
  int txn_n = 0, gap = 0, hold_bad = 0;
  bit held = 1'b0;
  logic [21:0] held_f = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // monitor
  always @(posedge clk_i) begin
    if (start_i) gap = 0;
    if (mgmt_req_o && !mgmt_done_i) begin
      if (held && held_f != {mgmt_reg_o, mgmt_we_o, mgmt_wdata_o}) hold_bad++;
      held = 1'b1;
      held_f = {mgmt_reg_o, mgmt_we_o, mgmt_wdata_o};
    end else if (mgmt_req_o && mgmt_done_i) begin
      if (held && held_f != {mgmt_reg_o, mgmt_we_o, mgmt_wdata_o}) hold_bad++;
      if (txn_n < LOGN) begin
        lg_reg[txn_n] = mgmt_reg_o; lg_we[txn_n] = mgmt_we_o;
        lg_wd[txn_n] = mgmt_wdata_o; lg_gap[txn_n] = gap;
      end
      txn_n++;
      gap = 0;
      held = 1'b0;
    end else begin
      held = 1'b0;
      if (tick_i) gap++;
    end
  end

  // tick source and PHY model
  always @(negedge clk_i) begin
    tick_ph = ~tick_ph;
    tick_i = tick_en && tick_ph;
    if (!rst_ni) begin
      mgmt_done_i = 1'b0; m_wait = 0;
    end else if (mgmt_done_i) begin
      mgmt_done_i = 1'b0; m_wait = 0;
    end else if (mgmt_req_o) begin
      if (m_wait >= m_lat) begin
        mgmt_done_i = 1'b1;
        mgmt_rdata_i = 16'h0000;
        if (!mgmt_we_o && mgmt_reg_o == 5'd0) begin
          mgmt_rdata_i = (m_r0 < m_rbusy) ? 16'h8000 : 16'h7FFF;
          m_r0++;
        end else if (!mgmt_we_o && mgmt_reg_o == 5'd1) begin
          mgmt_rdata_i = (m_aneg != 255 && m_r1 >= m_aneg) ? 16'h0020 : 16'hFFDF;
          m_r1++;
        end
      end else m_wait++;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic setup(input int rb, input int an, input int lat);
    m_rbusy = rb; m_aneg = an; m_lat = lat; m_r0 = 0; m_r1 = 0;
    txn_n = 0; hold_bad = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic wait_end();
    while (!done_o) @(negedge clk_i);
  endtask

  task automatic run_vec(input vec_t v);
    int rd0_bad, rd1_bad, rs_cnt, base;
    setup(int'(v.rbusy), int'(v.aneg_at), int'(v.lat));
    pulse_start();
    wait_end();
    cycles(20);
    rd0_bad = 0; rd1_bad = 0; rs_cnt = 0;
    for (int i = 0; i < txn_n && i < LOGN; i++) begin
      if (lg_reg[i] == 5'd0 && !lg_we[i] && lg_gap[i] != TB_WAIT) rd0_bad++;
      if (lg_reg[i] == 5'd1 && !lg_we[i] && lg_gap[i] < TB_WAIT) rd1_bad++;
      if (lg_reg[i] == 5'd0 && lg_we[i] && lg_wd[i] == 16'h1200) rs_cnt++;
    end
    chk(lg_reg[0] == 5'd0 && lg_we[0] && lg_wd[0] == 16'h8000, "R2 first access write 0x8000 reg0",
        int'(lg_wd[0]), 32768);
    chk(rd0_bad == 0, "R3 reset poll read spacing", rd0_bad, 0);
    chk(txn_n == int'(v.txn), "R8 access count", txn_n, int'(v.txn));
    chk(rs_cnt == int'(v.rst_wr), "R6 restart writes", rs_cnt, int'(v.rst_wr));
    chk(rd1_bad == 0, "R7 status read spacing", rd1_bad, 0);
    chk(link_up_o == v.link, "R7 link_up", int'(link_up_o), int'(v.link));
    chk(fail_o == v.fail, "R4 R8 fail", int'(fail_o), int'(v.fail));
    chk(done_o && !busy_o && !mgmt_req_o, "R10 done held, idle", int'(done_o), 1);
    chk(hold_bad == 0, "R9 request fields held", hold_bad, 0);
    if (!(v.fail && v.rst_wr == 0)) begin
      base = int'(v.rbusy) + 2;
      chk(lg_reg[base] == 5'd19 && lg_we[base] && lg_wd[base] == 16'h3FC0,
          "R5 interrupt mask write", int'(lg_wd[base]), 16320);
      chk(lg_reg[base+1] == 5'd4 && lg_we[base+1] && lg_wd[base+1] == 16'h01E1 &&
          lg_gap[base+1] == 0, "R5 advertisement write", int'(lg_wd[base+1]), 481);
      chk(lg_gap[base+2] >= TB_WAIT && lg_wd[base+2] == 16'h1200,
          "R5 R6 wait before first restart", lg_gap[base+2], TB_WAIT);
    end
  endtask

  initial begin
    int t0;
    // R1 reset state
    cycles(3);
    chk(!busy_o && !done_o && !link_up_o && !fail_o && !mgmt_req_o, "R1 reset state",
        int'({busy_o, done_o, link_up_o, fail_o, mgmt_req_o}), 0);
    rst_ni = 1'b1;
    cycles(2);
    chk(!busy_o && !done_o && !mgmt_req_o, "R1 idle after reset", int'(busy_o), 0);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R2 start while busy is ignored
    setup(2, 9, 1);
    pulse_start();
    cycles(30);
    pulse_start();
    wait_end();
    chk(txn_n == 18 && link_up_o, "R2 start while busy ignored", txn_n, 18);

    // R10 new start clears flags one cycle later
    pulse_start();
    chk(busy_o && !done_o && !link_up_o && !fail_o, "R10 start clears flags",
        int'(done_o), 0);
    wait_end();

    // R3 no ticks, no progress
    setup(0, 0, 0);
    tick_en = 1'b0;
    pulse_start();
    cycles(40);
    chk(txn_n == 1 && busy_o, "R3 wait holds without ticks", txn_n, 1);
    tick_en = 1'b1;
    wait_end();
    chk(link_up_o && txn_n == 6, "R3 resumes after ticks", txn_n, 6);

    // R10 flags hold across idle cycles
    t0 = txn_n;
    cycles(50);
    chk(link_up_o && done_o && !fail_o && txn_n == t0, "R10 flags hold while idle",
        int'(link_up_o), 1);

    // R1 asynchronous reset mid-run
    setup(0, 255, 0);
    pulse_start();
    cycles(25);
    #2 rst_ni = 1'b0;
    #1;
    chk(!busy_o && !done_o && !mgmt_req_o && !fail_o, "R1 reset mid-run",
        int'({busy_o, done_o, mgmt_req_o}), 0);
    cycles(2);
    rst_ni = 1'b1;
    cycles(2);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule